// File: doc/BRIEF.md
# Multi-channel serial readout deserializer

This block collects the serial bit streams shifted out of pixel-matrix detector chips and packs them into 32-bit words for a host processor. It drives a per-channel shift strobe and a per-channel enable toward the chips. It watches a ready line coming back from each chip. It counts the shift clocks of a frame against a fixed budget, which is derived from the matrix size and the pixel counter depth, and it stops once that budget is spent. Finished words go into a small output FIFO, and the host drains it with a read strobe.

Two read modes are offered, chosen when a frame starts. In parallel mode every channel carries its own chip. The word is split into byte-wide segments, and each segment fills from one chip at the same time as the others. In single-stream mode one chip, or a daisy chain of chips, arrives on channel 0 alone. The frame then lasts as many times the single-chip budget as there are channels, and the whole 32-bit word fills from that one line. The last word of a frame is left-justified and padded with zeros when it is incomplete. A one-cycle done pulse follows the final shift.

Top module: `serial_frame_deser`

## Requirements
- R1: After reset, sclk_o and sen_o are 0, rd_empty is 1, done and overflow are 0, and rd_data is 0.
- R2: A start pulse begins a frame only while no frame is running. It samples single_mode and clears overflow. A start during a running frame is ignored.
- R3: When single_mode is 0, segment k (rd_data bits 8k+7 down to 8k) holds the bits of channel k in arrival order, with the first bit at bit 8k+7. A word completes after 8 shift clocks.
- R4: When single_mode is 1, only channel 0 is used and the word fills from bit 31 down to bit 0 over 32 shift clocks. sdata_i and sen_i bits 1 to 3 have no effect, and sclk_o and sen_o bits 1 to 3 stay 0.
- R5: A parallel frame lasts exactly FRAME_CLKS shift clocks and a single-stream frame lasts exactly 4*FRAME_CLKS. When the frame ends, sen_o returns to 0.
- R6: While a frame runs, sen_o equals the active channel mask (4'b1111 in parallel mode, 4'b0001 in single-stream mode). A shift takes place, and sclk_o equals the mask, only in a cycle where every active channel has its sen_i bit high. Otherwise sclk_o is 0 and the frame does not advance.
- R7: The last word of a frame, if incomplete, keeps its collected bits at the top of each segment (parallel) or of the word (single-stream), and the remaining low bits are 0.
- R8: done is high for one cycle, in the cycle after the final shift. By then the final word has already entered the FIFO.
- R9: The FIFO keeps word order. rd_data carries the oldest word in the cycle after rd_en is sampled high while rd_empty is 0. rd_en while the FIFO is empty leaves rd_data unchanged.
- R10: A word that completes while the FIFO holds 8 words, with no read in the same cycle, is dropped and sets overflow. overflow stays set until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Frame start request |
| single_mode | input | 1 | 1: single stream on channel 0, 0: all channels in parallel |
| sdata_i | input | 4 | Serial data bit per channel |
| sen_i | input | 4 | Per-channel ready from the chip |
| sclk_o | output | 4 | Per-channel shift strobe, high in shift cycles |
| sen_o | output | 4 | Per-channel readout enable during a frame |
| rd_en | input | 1 | Host read strobe |
| rd_data | output | 32 | Word read from the FIFO |
| rd_empty | output | 1 | FIFO holds no word |
| done | output | 1 | One-cycle end-of-frame pulse |
| overflow | output | 1 | Sticky word-dropped flag |

## Verification
Frames in both modes carry random bits with a different stream on each channel. A swapped segment, a reversed bit order or a wrong mode selection therefore shows up in rd_data. Runs with no stalls pin down the exact word and frame cadence. Random ready dropouts, including dropouts on inactive channels in single-stream mode, show whether the frame stalls only on the lines it uses. The bench also drives host reads at several rates: none at all, to fill the FIFO and force a dropped word; bursts after a frame; and reads interleaved with pushes. These separate correct ordering and hold behaviour from off-by-one pointer faults. The frame length of 21 clocks ends both modes on a partial word, which exercises the zero padding.

// File: rtl/sfd_pkg.sv
// Shared types for the serial frame deserializer.
package sfd_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } run_state_t;

    typedef enum logic {
        MODE_PAR    = 1'b0,
        MODE_SINGLE = 1'b1
    } read_mode_t;
endpackage

// File: rtl/sfd_ctrl.sv
// Frame sequencer: accepts start, latches the mode, counts shift clocks
// against the frame budget and tracks the fill position of the current word.
// Assumes NCH >= 2. One shift takes place per core cycle while all active
// channels report ready.
module sfd_ctrl
    import sfd_pkg::*;
#(
    parameter int NCH        = 4,
    parameter int SEG_W      = 8,
    parameter int FRAME_CLKS = 917512
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           start,
    input  logic                           mode_sel,
    input  logic [NCH-1:0]                 chan_ready,
    output logic                           accept,
    output logic                           advance,
    output logic                           word_done,
    output logic                           single,
    output logic                           running,
    output logic [NCH-1:0]                 mask,
    output logic [$clog2(NCH*SEG_W)-1:0]   fill_pos,
    output logic                           done
);
    localparam int WORD_W = NCH * SEG_W;
    localparam int POS_W  = $clog2(WORD_W);
    localparam int CNT_W  = $clog2(NCH * FRAME_CLKS + 1);
    localparam logic [CNT_W-1:0] PAR_LAST = CNT_W'(FRAME_CLKS - 1);
    localparam logic [CNT_W-1:0] SGL_LAST = CNT_W'(NCH * FRAME_CLKS - 1);
    localparam logic [POS_W-1:0] PAR_POS  = POS_W'(SEG_W - 1);
    localparam logic [POS_W-1:0] SGL_POS  = POS_W'(WORD_W - 1);

    run_state_t       state;
    read_mode_t       mode_q;
    logic [CNT_W-1:0] clk_cnt;
    logic [POS_W-1:0] pos;
    logic             last_shift;

    // Active-channel mask and shift qualification
    always_comb begin
        single     = (mode_q == MODE_SINGLE);
        running    = (state == ST_RUN);
        mask       = single ? NCH'(1) : {NCH{1'b1}};
        accept     = (state == ST_IDLE) && start;
        advance    = running && ((chan_ready & mask) == mask);
        last_shift = advance && (clk_cnt == (single ? SGL_LAST : PAR_LAST));
        word_done  = advance && (last_shift || (pos == (single ? SGL_POS : PAR_POS)));
        fill_pos   = pos;
    end

    // Frame state, clock budget counter and word fill position
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            mode_q  <= MODE_PAR;
            clk_cnt <= '0;
            pos     <= '0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            if (accept) begin
                state   <= ST_RUN;
                mode_q  <= read_mode_t'(mode_sel);
                clk_cnt <= '0;
                pos     <= '0;
            end else if (advance) begin
                clk_cnt <= clk_cnt + 1'b1;
                pos     <= word_done ? '0 : pos + 1'b1;
                if (last_shift) begin
                    state <= ST_IDLE;
                    done  <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/sfd_assembler.sv
// Word assembler: shifts serial bits into per-channel segments (parallel) or
// into the whole word from channel 0 (single stream). It presents the
// completed, left-justified word in the cycle that completes it.
// Assumes fill_pos < SEG_W whenever parallel mode is active.
module sfd_assembler #(
    parameter int NCH   = 4,
    parameter int SEG_W = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           clear,
    input  logic                           shift_en,
    input  logic                           single,
    input  logic                           word_done,
    input  logic [$clog2(NCH*SEG_W)-1:0]   fill_pos,
    input  logic [NCH-1:0]                 din,
    output logic [NCH*SEG_W-1:0]           word_o
);
    localparam int WORD_W = NCH * SEG_W;
    localparam int POS_W  = $clog2(WORD_W);

    logic [WORD_W-1:0] sreg;
    logic [WORD_W-1:0] par_nxt;
    logic [WORD_W-1:0] par_pad;
    logic [WORD_W-1:0] sgl_nxt;
    logic [WORD_W-1:0] sgl_pad;
    logic [POS_W-1:0]  par_sh;
    logic [POS_W-1:0]  sgl_sh;

    // Left-justify amounts for a partially filled segment or word
    always_comb begin
        par_sh = POS_W'(SEG_W - 1) - fill_pos;
        sgl_sh = POS_W'(WORD_W - 1) - fill_pos;
    end

    // One independent shift segment per channel
    for (genvar k = 0; k < NCH; k++) begin : g_seg
        logic [SEG_W-1:0] seg_n;
        assign seg_n = {sreg[k*SEG_W +: SEG_W-1], din[k]};
        assign par_nxt[k*SEG_W +: SEG_W] = seg_n;
        assign par_pad[k*SEG_W +: SEG_W] = seg_n << par_sh;
    end

    // Whole-word shift from channel 0 and output selection
    always_comb begin
        sgl_nxt = {sreg[WORD_W-2:0], din[0]};
        sgl_pad = sgl_nxt << sgl_sh;
        word_o  = single ? sgl_pad : par_pad;
    end

    // Shift register: clears at frame start and after each completed word
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            sreg <= '0;
        end else if (shift_en) begin
            sreg <= word_done ? '0 : (single ? sgl_nxt : par_nxt);
        end
    end
endmodule

// File: rtl/sfd_fifo.sv
// Output word FIFO with a registered read port and a sticky overflow flag.
// A push that finds the FIFO full is dropped unless a read frees a slot in the
// same cycle.
module sfd_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         rd_en,
    input  logic         clr_ovf,
    output logic [W-1:0] rdata,
    output logic         empty,
    output logic         ovf
);
    localparam int AW = $clog2(DEPTH);
    localparam logic [AW-1:0] LAST_IX = AW'(DEPTH - 1);
    localparam logic [AW:0]   FULL_N  = (AW+1)'(DEPTH);

    logic [W-1:0] mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [AW:0]   cnt;
    logic          pop, take;

    // Read and write qualification
    always_comb begin
        empty = (cnt == '0);
        pop   = rd_en && !empty;
        take  = push && ((cnt != FULL_N) || pop);
    end

    // Storage write
    always_ff @(posedge clk) begin
        if (take) mem[wp] <= wdata;
    end

    // Pointers, occupancy, read register and overflow flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            cnt   <= '0;
            rdata <= '0;
            ovf   <= 1'b0;
        end else begin
            if (take) wp <= (wp == LAST_IX) ? '0 : wp + 1'b1;
            if (pop) begin
                rdata <= mem[rp];
                rp    <= (rp == LAST_IX) ? '0 : rp + 1'b1;
            end
            cnt <= cnt + (take ? 1'b1 : 1'b0) - (pop ? 1'b1 : 1'b0);
            if (clr_ovf)          ovf <= 1'b0;
            else if (push && !take) ovf <= 1'b1;
        end
    end
endmodule

// File: rtl/serial_frame_deser.sv
// Top level: sequencer, word assembler and output FIFO. Strobes and enables
// toward the chips are combinational from the sequencer state and the ready
// inputs, so an external clock gate can use sclk_o directly.
module serial_frame_deser #(
    parameter int NCH        = 4,
    parameter int SEG_W      = 8,
    parameter int FRAME_CLKS = 917512,
    parameter int FIFO_DEPTH = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 single_mode,
    input  logic [NCH-1:0]       sdata_i,
    input  logic [NCH-1:0]       sen_i,
    output logic [NCH-1:0]       sclk_o,
    output logic [NCH-1:0]       sen_o,
    input  logic                 rd_en,
    output logic [NCH*SEG_W-1:0] rd_data,
    output logic                 rd_empty,
    output logic                 done,
    output logic                 overflow
);
    localparam int WORD_W = NCH * SEG_W;
    localparam int POS_W  = $clog2(WORD_W);

    logic             accept, advance, word_done, single, running;
    logic [NCH-1:0]   mask;
    logic [POS_W-1:0] fill_pos;
    logic [WORD_W-1:0] word;

    sfd_ctrl #(.NCH(NCH), .SEG_W(SEG_W), .FRAME_CLKS(FRAME_CLKS)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .mode_sel(single_mode),
        .chan_ready(sen_i), .accept(accept), .advance(advance),
        .word_done(word_done), .single(single), .running(running),
        .mask(mask), .fill_pos(fill_pos), .done(done)
    );

    sfd_assembler #(.NCH(NCH), .SEG_W(SEG_W)) u_asm (
        .clk(clk), .rst_n(rst_n), .clear(accept), .shift_en(advance),
        .single(single), .word_done(word_done), .fill_pos(fill_pos),
        .din(sdata_i), .word_o(word)
    );

    sfd_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(word_done), .wdata(word),
        .rd_en(rd_en), .clr_ovf(accept), .rdata(rd_data),
        .empty(rd_empty), .ovf(overflow)
    );

    // Chip-facing enable and shift strobe
    always_comb begin
        sen_o  = running ? mask : '0;
        sclk_o = advance ? mask : '0;
    end
endmodule

// File: rtl/sfd_chk.sv
// Protocol checker for serial_frame_deser, attached by bind.
module sfd_chk #(
    parameter int NCH = 4,
    parameter int W   = 32
) (
    input logic           clk,
    input logic           rst_n,
    input logic           start,
    input logic [NCH-1:0] sclk_o,
    input logic [NCH-1:0] sen_o,
    input logic           rd_en,
    input logic [W-1:0]   rd_data,
    input logic           rd_empty,
    input logic           done,
    input logic           overflow
);
    // R6
    strobe_in_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_o & ~sen_o) == '0);
    // R4
    enable_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sen_o == '0) || (sen_o == {NCH{1'b1}}) || (sen_o == NCH'(1)));
    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R8
    done_after_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(sclk_o) != '0);
    // R5
    idle_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> sen_o == '0);
    // R9
    empty_read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_empty) |=> $stable(rd_data));
    // R9
    no_read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));
    // R10
    overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && !start) |=> overflow);
endmodule

bind serial_frame_deser sfd_chk #(.NCH(NCH), .W(NCH*SEG_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .sclk_o(sclk_o), .sen_o(sen_o),
    .rd_en(rd_en), .rd_data(rd_data), .rd_empty(rd_empty), .done(done),
    .overflow(overflow)
);

// File: tb/sim_serial_frame_deser.sv
module sim_serial_frame_deser;
    localparam int NCH   = 4;
    localparam int FRAME = 21;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        single_mode = 1'b0;
    logic [3:0]  sdata_i = '0;
    logic [3:0]  sen_i = '0;
    logic [3:0]  sclk_o, sen_o;
    logic        rd_en = 1'b0;
    logic [31:0] rd_data;
    logic        rd_empty, done, overflow;

    serial_frame_deser #(.NCH(NCH), .SEG_W(8), .FRAME_CLKS(FRAME), .FIFO_DEPTH(8)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .single_mode(single_mode),
        .sdata_i(sdata_i), .sen_i(sen_i), .sclk_o(sclk_o), .sen_o(sen_o),
        .rd_en(rd_en), .rd_data(rd_data), .rd_empty(rd_empty), .done(done),
        .overflow(overflow)
    );

    always #4 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // stimulus knobs
    int  stall_pct = 0;
    int  rd_pct    = 0;
    bit  start_req = 0;
    bit  mode_req  = 0;
    bit  cmp_on    = 0;

    // behavioural reference
    bit          m_run = 0, m_single = 0, m_done = 0, m_ovf = 0;
    int          m_cnt = 0, m_bits = 0, m_shifts = 0;
    logic [7:0]  m_seg [4];
    logic [31:0] m_acc = '0, m_rd = '0;
    logic [31:0] m_q [$];

    function automatic logic [3:0] m_mask();
        return m_single ? 4'b0001 : 4'b1111;
    endfunction

    function automatic bit m_ready(input logic [3:0] en);
        return m_run && ((en & m_mask()) == m_mask());
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_run = 0; m_single = 0; m_done = 0; m_ovf = 0; m_rd = '0;
            m_cnt = 0; m_bits = 0; m_acc = '0; m_q.delete();
            foreach (m_seg[i]) m_seg[i] = '0;
        end else begin
            m_done = 0;
            if (rd_en && m_q.size() > 0) m_rd = m_q.pop_front();
            if (!m_run && start) begin
                m_run = 1; m_single = single_mode; m_ovf = 0;
                m_cnt = 0; m_bits = 0; m_acc = '0; m_shifts = 0;
                foreach (m_seg[i]) m_seg[i] = '0;
            end else if (m_ready(sen_i)) begin
                logic [31:0] w;
                bit last;
                m_cnt++; m_bits++; m_shifts++;
                if (m_single) m_acc = {m_acc[30:0], sdata_i[0]};
                else foreach (m_seg[i]) m_seg[i] = {m_seg[i][6:0], sdata_i[i]};
                last = (m_cnt == (m_single ? NCH*FRAME : FRAME));
                if (last || m_bits == (m_single ? 32 : 8)) begin
                    if (m_single) w = m_acc << (32 - m_bits);
                    else for (int i = 0; i < 4; i++) w[8*i +: 8] = m_seg[i] << (8 - m_bits);
                    if (m_q.size() < 8) m_q.push_back(w);
                    else m_ovf = 1;
                    m_bits = 0; m_acc = '0;
                    foreach (m_seg[i]) m_seg[i] = '0;
                end
                if (last) begin m_run = 0; m_done = 1; end
            end
        end
    end

    // compare every cycle, then drive the next inputs
    always @(negedge clk) begin
        if (cmp_on) begin
            check("R4 R6 sclk_o", {28'd0, sclk_o}, m_ready(sen_i) ? {28'd0, m_mask()} : 32'd0);
            check("R5 R6 sen_o", {28'd0, sen_o}, m_run ? {28'd0, m_mask()} : 32'd0);
            check("R8 done", {31'd0, done}, {31'd0, m_done});
            check("R9 rd_empty", {31'd0, rd_empty}, {31'd0, m_q.size() == 0});
            check("R10 overflow", {31'd0, overflow}, {31'd0, m_ovf});
            check("R3 R4 R7 R9 rd_data", rd_data, m_rd);
            // R5: shift clock total per frame
            if (m_done) check("R5 frame shift count", m_shifts, m_single ? NCH*FRAME : FRAME);
        end
        start       = start_req;
        single_mode = mode_req;
        start_req   = 0;
        sdata_i     = 4'($urandom);
        for (int i = 0; i < 4; i++) sen_i[i] = (($urandom % 100) >= stall_pct);
        rd_en       = (($urandom % 100) < rd_pct);
    end

    task automatic run_frame(input bit single, input int stall, input int rdp);
        stall_pct = stall; rd_pct = rdp; mode_req = single;
        @(posedge clk); start_req = 1;
        repeat (3) @(posedge clk);
        // R2: a start request while the frame runs must be ignored
        start_req = 1; mode_req = ~single;
        @(posedge clk); mode_req = single;
        while (m_run) @(posedge clk);
        repeat (2) @(posedge clk);
    endtask

    task automatic drain();
        stall_pct = 0; rd_pct = 100;
        repeat (12) @(posedge clk);
        rd_pct = 0;
        repeat (2) @(posedge clk);
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        // R1 reset state
        check("R1 sclk_o", {28'd0, sclk_o}, 32'd0);
        check("R1 sen_o", {28'd0, sen_o}, 32'd0);
        check("R1 rd_empty", {31'd0, rd_empty}, 32'd1);
        check("R1 done", {31'd0, done}, 32'd0);
        check("R1 overflow", {31'd0, overflow}, 32'd0);
        check("R1 rd_data", rd_data, 32'd0);
        @(negedge clk); rst_n = 1; cmp_on = 1;
        repeat (2) @(posedge clk);
        // R3 R7: parallel, no stalls, read after frame
        run_frame(0, 0, 0);
        drain();
        // R4 R7: single stream, stalls, interleaved reads
        run_frame(1, 30, 50);
        drain();
        // R6: parallel with stalls on any channel, reads interleaved
        run_frame(0, 30, 40);
        drain();
        // R10: three parallel frames with no reads overfill the FIFO
        run_frame(0, 10, 0);
        run_frame(0, 10, 0);
        run_frame(0, 10, 0);
        #1 check("R10 overflow after full", {31'd0, overflow}, 32'd1);
        drain();
        // R2 R10: next start clears overflow; single stream, no stalls
        run_frame(1, 0, 0);
        #1 check("R2 overflow cleared by start", {31'd0, overflow}, 32'd0);
        drain();
        // R9: read with the FIFO empty keeps rd_data
        rd_pct = 100;
        repeat (5) @(posedge clk);
        rd_pct = 0;
        repeat (2) @(posedge clk);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule